// File: doc/BRIEF.md
# Virtual-Channel Router Input Port

This block is the receive side of a single router port. Flits arrive over one physical link, each tagged with a virtual-channel number and a flit kind. Every virtual channel owns a small queue of its own, so a packet that cannot advance on one channel never holds up traffic on another channel sharing the same wire. Upstream credit accounting is expected to keep each queue from being overrun.

For every channel the block keeps per-packet context. When a head flit reaches the front of its queue, a pluggable combinational lookup derives the output port from the flit payload, and the result is registered. The channel then requests an output virtual channel from an external allocator and records the one it is granted. The body and tail flits of the packet reuse both values without recomputing them. Once a channel holds both values, it raises a switch request whenever its queue is non-empty. A grant from the switch allocator pops the front flit. Popping the last flit of a packet frees the channel for the next head.

Top module: `vcin_port`

## Requirements
- R1: After reset every queue is empty, no channel raises a VC-allocation or switch request, and the overflow flag is low.
- R2: A flit with `inValid` high is appended to the queue selected by `inVc`. Each channel queue holds up to DEPTH flits (3 by default) and delivers them in arrival order on `frontData`/`frontType`.
- R3: The flit kind is coded as 2'b00 body, 2'b01 head, 2'b10 tail and 2'b11 single-flit packet (head and tail in one). A kind of 2'b10 or 2'b11 ends a packet.
- R4: The output port is `data % NUM_OUT`, taken from the head flit's payload. It is computed once per packet. With the channel idle, a head reaching the front raises `vaReq` two clock edges later, and `routePort` holds the result from that point.
- R5: `vaReq` stays high until `vaGnt` for that channel is seen. The value on that channel's `vaGntVc` is then captured into `outVc`, and `vaReq` drops on the next edge.
- R6: Once `outVc` is assigned, the channel raises `saReq` exactly when its queue is non-empty. `routePort` and `outVc` stay unchanged for the body and tail flits of the packet.
- R7: A `saGnt` bit pops the front flit of its channel only while that channel's `saReq` is high. Otherwise the bit is ignored.
- R8: Popping a flit of kind tail or single-flit returns the channel to idle on that same edge. The next head in the queue is then routed anew.
- R9: A channel whose switch requests are never granted does not stop another channel on the same port from delivering flits.
- R10: A flit written to a channel that already holds DEPTH flits is discarded, even if that channel pops in the same cycle. The discard sets `overflowErr`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Flit present on the link this cycle |
| inVc | input | VC_W | Virtual channel of the incoming flit |
| inType | input | 2 | Flit kind (R3 coding) |
| inData | input | DATA_W | Flit payload |
| vaGnt | input | NUM_VC | Output-VC grant, one bit per channel |
| vaGntVc | input | NUM_VC x OVC_W | Granted output VC for each channel |
| saGnt | input | NUM_VC | Switch grant, pops the front flit of a channel |
| vaReq | output | NUM_VC | Channel waits for an output VC |
| saReq | output | NUM_VC | Channel has a routed flit ready for the switch |
| routePort | output | NUM_VC x PORT_W | Output port of each channel's current packet |
| outVc | output | NUM_VC x OVC_W | Output VC of each channel's current packet |
| frontType | output | NUM_VC x 2 | Kind of the flit at each queue front |
| frontData | output | NUM_VC x DATA_W | Payload of the flit at each queue front |
| overflowErr | output | 1 | Sticky: a flit arrived at a full queue |

## Verification
The properties assume that flits on each channel form well-formed packets: a head or single-flit packet first, then bodies, then a tail. They also assume that the front of an idle channel is always a head. The bench generates traffic with a per-channel packet builder that never breaks this order. It only exceeds a queue's capacity in a final phase built for that purpose, where the dropped flits are expected. The allocator grants are driven at random, including switch grants to channels that are not requesting, so the ignore rule is exercised throughout the run.

// File: rtl/vcin_pkg.sv
package vcin_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ROUTE  = 2'd1,
    ST_WAITVC = 2'd2,
    ST_ACTIVE = 2'd3
  } vcState_t;

  localparam logic [1:0] FT_BODY   = 2'b00;
  localparam logic [1:0] FT_HEAD   = 2'b01;
  localparam logic [1:0] FT_TAIL   = 2'b10;
  localparam logic [1:0] FT_SINGLE = 2'b11;

  // per-channel strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic latchRoute;
    logic latchVc;
  } vcStrobe_t;

  function automatic logic endsPacket(input logic [1:0] kind);
    return (kind == FT_TAIL) || (kind == FT_SINGLE);
  endfunction

endpackage

// File: rtl/vcin_route.sv
module vcin_route #(
  parameter int DATA_W  = 16,
  parameter int NUM_OUT = 5,
  parameter int PORT_W  = 3
) (
  input  logic [DATA_W-1:0] flitData,
  output logic [PORT_W-1:0] port
);
  // replaceable lookup: destination is the payload reduced by the port count
  logic [DATA_W-1:0] rem;
  assign rem  = flitData % DATA_W'(NUM_OUT);
  assign port = rem[PORT_W-1:0];

  logic unusedHi;
  assign unusedHi = ^rem;
endmodule

// File: rtl/vcin_datapath.sv
module vcin_datapath
  import vcin_pkg::*;
#(
  parameter int NUM_VC  = 2,
  parameter int DEPTH   = 3,
  parameter int DATA_W  = 16,
  parameter int NUM_OUT = 5,
  parameter int PORT_W  = 3,
  parameter int OVC_W   = 1
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [1:0]                         inType,
  input  logic [DATA_W-1:0]                  inData,
  input  logic [NUM_VC-1:0][OVC_W-1:0]       vaGntVc,
  input  vcStrobe_t [NUM_VC-1:0]             strobes,
  output logic [NUM_VC-1:0][PORT_W-1:0]      routePort,
  output logic [NUM_VC-1:0][OVC_W-1:0]       outVc,
  output logic [NUM_VC-1:0][1:0]             frontType,
  output logic [NUM_VC-1:0][DATA_W-1:0]      frontData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ENT_W = DATA_W + 2;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic [ENT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wrPtr, rdPtr;
    logic [PORT_W-1:0] lookupPort;
    logic [ENT_W-1:0] frontEnt;

    assign frontEnt = mem[rdPtr];

    vcin_route #(.DATA_W(DATA_W), .NUM_OUT(NUM_OUT), .PORT_W(PORT_W)) u_route (
      .flitData(frontEnt[DATA_W-1:0]),
      .port    (lookupPort)
    );

    always_ff @(posedge clk) begin
      if (strobes[v].push) mem[wrPtr] <= {inType, inData};
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        routePort[v] <= '0;
        outVc[v] <= '0;
      end else begin
        if (strobes[v].push)
          wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        if (strobes[v].pop)
          rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        if (strobes[v].latchRoute) routePort[v] <= lookupPort;
        if (strobes[v].latchVc)    outVc[v] <= vaGntVc[v];
      end
    end

    assign frontType[v] = frontEnt[ENT_W-1:DATA_W];
    assign frontData[v] = frontEnt[DATA_W-1:0];
  end
endmodule

// File: rtl/vcin_ctrl.sv
module vcin_ctrl
  import vcin_pkg::*;
#(
  parameter int NUM_VC = 2,
  parameter int DEPTH  = 3,
  parameter int VC_W   = 1,
  parameter int CNT_W  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [VC_W-1:0]         inVc,
  input  logic [NUM_VC-1:0]       vaGnt,
  input  logic [NUM_VC-1:0]       saGnt,
  input  logic [NUM_VC-1:0][1:0]  frontType,
  output vcStrobe_t [NUM_VC-1:0]  strobes,
  output logic [NUM_VC-1:0]       vaReq,
  output logic [NUM_VC-1:0]       saReq,
  output logic                    overflowErr
);
  logic [NUM_VC-1:0] dropHit;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    vcState_t  state;
    logic [CNT_W-1:0] count;
    logic hit, full, pushOk, popOk, notEmpty;

    assign hit      = inValid && (inVc == VC_W'(v));
    assign full     = (count == CNT_W'(DEPTH));
    assign notEmpty = (count != '0);
    assign pushOk   = hit && !full;
    assign popOk    = (state == ST_ACTIVE) && notEmpty && saGnt[v];
    assign dropHit[v] = hit && full;

    assign strobes[v].push       = pushOk;
    assign strobes[v].pop        = popOk;
    assign strobes[v].latchRoute = (state == ST_ROUTE);
    assign strobes[v].latchVc    = (state == ST_WAITVC) && vaGnt[v];

    assign vaReq[v] = (state == ST_WAITVC);
    assign saReq[v] = (state == ST_ACTIVE) && notEmpty;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        state <= ST_IDLE;
        count <= '0;
      end else begin
        count <= count + CNT_W'(pushOk) - CNT_W'(popOk);
        case (state)
          ST_IDLE:   if (notEmpty) state <= ST_ROUTE;
          ST_ROUTE:  state <= ST_WAITVC;
          ST_WAITVC: if (vaGnt[v]) state <= ST_ACTIVE;
          ST_ACTIVE: if (popOk && endsPacket(frontType[v])) state <= ST_IDLE;
          default:   state <= ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         overflowErr <= 1'b0;
    else if (|dropHit) overflowErr <= 1'b1;
  end
endmodule

// File: rtl/vcin_port.sv
module vcin_port
  import vcin_pkg::*;
#(
  parameter int NUM_VC  = 2,
  parameter int DEPTH   = 3,
  parameter int DATA_W  = 16,
  parameter int NUM_OUT = 5,
  parameter int OUT_VCS = 2,
  localparam int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int PORT_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  localparam int OVC_W  = (OUT_VCS > 1) ? $clog2(OUT_VCS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic [VC_W-1:0]               inVc,
  input  logic [1:0]                    inType,
  input  logic [DATA_W-1:0]             inData,
  input  logic [NUM_VC-1:0]             vaGnt,
  input  logic [NUM_VC-1:0][OVC_W-1:0]  vaGntVc,
  input  logic [NUM_VC-1:0]             saGnt,
  output logic [NUM_VC-1:0]             vaReq,
  output logic [NUM_VC-1:0]             saReq,
  output logic [NUM_VC-1:0][PORT_W-1:0] routePort,
  output logic [NUM_VC-1:0][OVC_W-1:0]  outVc,
  output logic [NUM_VC-1:0][1:0]        frontType,
  output logic [NUM_VC-1:0][DATA_W-1:0] frontData,
  output logic                          overflowErr
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  vcStrobe_t [NUM_VC-1:0] strobes;

  vcin_ctrl #(.NUM_VC(NUM_VC), .DEPTH(DEPTH), .VC_W(VC_W), .CNT_W(CNT_W)) u_ctrl (
    .clk, .rstN, .inValid, .inVc, .vaGnt, .saGnt, .frontType,
    .strobes, .vaReq, .saReq, .overflowErr
  );

  vcin_datapath #(.NUM_VC(NUM_VC), .DEPTH(DEPTH), .DATA_W(DATA_W), .NUM_OUT(NUM_OUT),
                  .PORT_W(PORT_W), .OVC_W(OVC_W)) u_dp (
    .clk, .rstN, .inType, .inData, .vaGntVc, .strobes,
    .routePort, .outVc, .frontType, .frontData
  );
endmodule

// File: rtl/vcin_port_chk.sv
module vcin_port_chk
  import vcin_pkg::*;
#(
  parameter int NUM_VC = 2,
  parameter int PORT_W = 3,
  parameter int OVC_W  = 1
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [NUM_VC-1:0]             vaGnt,
  input logic [NUM_VC-1:0]             saGnt,
  input logic [NUM_VC-1:0]             vaReq,
  input logic [NUM_VC-1:0]             saReq,
  input logic [NUM_VC-1:0][PORT_W-1:0] routePort,
  input logic [NUM_VC-1:0][OVC_W-1:0]  outVc,
  input logic [NUM_VC-1:0][1:0]        frontType,
  input logic                          overflowErr
);
  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    // R5
    va_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      vaReq[v] && !vaGnt[v] |=> vaReq[v]);
    // R5
    va_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
      vaReq[v] && vaGnt[v] |=> !vaReq[v]);
    // R6
    req_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(vaReq[v] && saReq[v]));
    // R6
    ctx_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
      saReq[v] && !(saGnt[v] && endsPacket(frontType[v]))
      |=> $stable(routePort[v]) && $stable(outVc[v]));
    // R8
    tail_release_chk: assert property (@(posedge clk) disable iff (!rstN)
      saReq[v] && saGnt[v] && endsPacket(frontType[v]) |=> !saReq[v] && !vaReq[v]);
  end

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr);
endmodule

bind vcin_port vcin_port_chk #(.NUM_VC(NUM_VC), .PORT_W(PORT_W), .OVC_W(OVC_W)) u_chk (
  .clk(clk), .rstN(rstN), .vaGnt(vaGnt), .saGnt(saGnt), .vaReq(vaReq), .saReq(saReq),
  .routePort(routePort), .outVc(outVc), .frontType(frontType), .overflowErr(overflowErr)
);

// File: tb/vcin_port_tb.sv
module vcin_port_tb;
  localparam int NUM_VC = 2, DEPTH = 3, DATA_W = 16, NUM_OUT = 5, OUT_VCS = 2;
  localparam int VC_W = 1, PORT_W = 3, OVC_W = 1;

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0;
  logic [VC_W-1:0] inVc = '0;
  logic [1:0] inType = '0;
  logic [DATA_W-1:0] inData = '0;
  logic [NUM_VC-1:0] vaGnt = '0, saGnt = '0;
  logic [NUM_VC-1:0][OVC_W-1:0] vaGntVc = '0;
  logic [NUM_VC-1:0] vaReq, saReq;
  logic [NUM_VC-1:0][PORT_W-1:0] routePort;
  logic [NUM_VC-1:0][OVC_W-1:0] outVc;
  logic [NUM_VC-1:0][1:0] frontType;
  logic [NUM_VC-1:0][DATA_W-1:0] frontData;
  logic overflowErr;

  vcin_port #(.NUM_VC(NUM_VC), .DEPTH(DEPTH), .DATA_W(DATA_W), .NUM_OUT(NUM_OUT),
              .OUT_VCS(OUT_VCS)) u_dut (.*);

  always #5 clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // behavioural model: 0 idle, 1 routing, 2 waiting for VC, 3 active
  logic [17:0] mq [NUM_VC][$];
  int mSt [NUM_VC];
  int mRoute [NUM_VC];
  int mOvc [NUM_VC];
  bit mOvf;
  int sendLeft [NUM_VC];
  int vc1Pops;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    for (int v = 0; v < NUM_VC; v++) begin
      bit expVa, expSa;
      expVa = (mSt[v] == 2);
      expSa = (mSt[v] == 3) && (mq[v].size() > 0);
      chk(vaReq[v] == expVa, "R5 vaReq", vaReq[v], expVa);
      chk(saReq[v] == expSa, "R6 saReq", saReq[v], expSa);
      if (expVa || expSa)
        chk(routePort[v] == mRoute[v], "R4 routePort", routePort[v], mRoute[v]);
      if (expSa) begin
        chk(outVc[v] == mOvc[v], "R5 outVc", outVc[v], mOvc[v]);
        chk(frontType[v] == mq[v][0][17:16], "R2 frontType", frontType[v], mq[v][0][17:16]);
        chk(frontData[v] == mq[v][0][15:0], "R2 frontData", frontData[v], mq[v][0][15:0]);
      end
    end
    chk(overflowErr == mOvf, "R10 overflowErr", overflowErr, mOvf);
  endtask

  // one clock: compare, drive, advance model
  task automatic cycle(input bit allowSend, input bit blockVc0, input bit allowOvf,
                       input bit grantsOn);
    int v;
    @(negedge clk);
    compareAll();
    inValid = 1'b0;
    v = $urandom % NUM_VC;
    if (allowOvf) v = 0;
    if (allowSend && ($urandom % 4 != 0) && (allowOvf || mq[v].size() < DEPTH)) begin
      inValid = 1'b1;
      inVc = VC_W'(v);
      // R3 kind coding
      if (sendLeft[v] == 0) begin
        int len = 1 + $urandom % 4;
        inType = (len == 1) ? 2'b11 : 2'b01;
        sendLeft[v] = len - 1;
      end else begin
        sendLeft[v]--;
        inType = (sendLeft[v] == 0) ? 2'b10 : 2'b00;
      end
      inData = DATA_W'($urandom);
    end
    vaGnt = grantsOn ? NUM_VC'($urandom) : '0;
    for (int k = 0; k < NUM_VC; k++) vaGntVc[k] = OVC_W'($urandom);
    saGnt = grantsOn ? NUM_VC'($urandom) : '0;   // R7 bits also hit non-requesting channels
    if (blockVc0) saGnt[0] = 1'b0;
    for (int k = 0; k < NUM_VC; k++) begin
      int sz = mq[k].size();
      bit pop = saGnt[k] && mSt[k] == 3 && sz > 0;
      case (mSt[k])
        0: if (sz > 0) mSt[k] = 1;
        1: begin mSt[k] = 2; mRoute[k] = int'(mq[k][0][15:0]) % NUM_OUT; end
        2: if (vaGnt[k]) begin mSt[k] = 3; mOvc[k] = vaGntVc[k]; end
        3: if (pop && mq[k][0][17]) mSt[k] = 0;   // R8
        default: ;
      endcase
      if (pop) begin
        void'(mq[k].pop_front());
        if (k == 1) vc1Pops++;
      end
      if (inValid && inVc == VC_W'(k)) begin
        if (sz < DEPTH) mq[k].push_back({inType, inData});
        else mOvf = 1'b1;
      end
    end
  endtask

  initial begin
    for (int v = 0; v < NUM_VC; v++) begin
      mSt[v] = 0; mRoute[v] = 0; mOvc[v] = 0; sendLeft[v] = 0;
    end
    mOvf = 0; vc1Pops = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(vaReq == '0, "R1 vaReq after reset", vaReq, 0);
    chk(saReq == '0, "R1 saReq after reset", saReq, 0);
    chk(overflowErr == 1'b0, "R1 overflowErr after reset", overflowErr, 0);
    rstN = 1'b1;
    // R2 R4 R5 R6 R7 R8: mixed traffic
    repeat (3000) cycle(1, 0, 0, 1);
    // R9: channel 0 never granted
    vc1Pops = 0;
    repeat (300) cycle(1, 1, 0, 1);
    chk(vc1Pops > 0, "R9 channel 1 progress while channel 0 blocked", vc1Pops, 1);
    // drain
    repeat (200) cycle(0, 0, 0, 1);
    // R10: overrun channel 0 with grants off
    repeat (12) cycle(1, 0, 1, 0);
    chk(mOvf == 1'b1, "R10 overflow stimulus produced", mOvf, 1);
    repeat (60) cycle(0, 0, 0, 1);
    @(negedge clk);
    compareAll();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule